// File: doc/BRIEF.md
# Sensorless Spindle Start-Up Mode Controller

This block is the mode state machine of a sensorless three-phase spindle driver. It decides when the power bridge is driven, when it is tristated and when all low-side switches are closed for braking. It also tells an external six-step phase sequencer when to advance by one step or by two. When run is requested it first spends a short window looking for back-EMF zero crossings. If crossings arrive, the motor is still turning and the block re-locks onto it directly. If none arrive, it performs a timed two-step rotor alignment and then lets back-EMF crossings drive commutation.

The alignment steps are timed in edges of a slow, asynchronous align reference clock. A watchdog on that clock prevents the drivers from staying energised in one phase when the reference has stopped. When run is withdrawn, the bridge coasts for a programmable number of system clocks and then brakes. The timer block that measures phase period, delay and mask receives hold and load commands from this block. While the sequence-increment input is high in run mode, an external controller steps the sequencer by hand.

Top module: `spd_startup_ctrl`

## Requirements
- R1: After reset release with run low, the bridge is off (`drv_en_o`=0, `brake_o`=0), no step pulse is issued, `seq_home_o` is 1 from the first clock, and `brake_o` rises exactly BRK_DLY+1 clocks after the first clock edge with run low.
- R2: With run high, output enable high and the align clock present, the block waits CHK_CYC clocks for a zero crossing. If none comes, it issues one single-step pulse (sequencer state 1 to 2) and sets `drv_en_o` in the same cycle. Starting from brake, this occurs CHK_CYC+2 clocks after run rises.
- R3: The first alignment lasts A1_TICKS rising edges of the align clock (within one edge of synchronizer slack). It ends with a double-step pulse (state 2 to 4). `inc_o` and `inc2_o` are never high together.
- R4: The second alignment lasts A2_TICKS align edges and ends with a double-step pulse (state 4 to 6). Entry into the second alignment gives one `ld_min_o` pulse.
- R5: In run mode, each cycle with `zc_i`=1 and `seq_inc_i`=0 gives one `inc_o` pulse and one `ld_period_o` pulse on the next clock.
- R6: Levels and edges on `seq_inc_i` during either alignment step produce no step pulse.
- R7: In run mode, a rising edge of `seq_inc_i` gives one `inc_o` pulse and no `ld_period_o`. Zero crossings while `seq_inc_i` is high are ignored. A crossing that coincides with the rising edge still gives only one step.
- R8: A zero crossing seen during the spin check enters run mode directly: `drv_en_o` rises and `ld_min_o` pulses, with no step pulse.
- R9: If no align-clock rising edge has been seen for 2^WD_W-1 clocks, start-up is not begun, and an alignment in progress is abandoned with the bridge off.
- R10: Run low turns the bridge off on the next clock and sets `seq_home_o`. `brake_o` follows after BRK_DLY+1 clocks, and `brake_o` never coincides with `drv_en_o`.
- R11: Output enable low forces `drv_en_o` and `brake_o` low in the same cycle. Any driving or checking mode returns to idle, and a later enable restarts with the spin check.
- R12: Run low takes priority over an alignment time-out, a zero crossing or a manual step in the same cycle: no step pulse follows the drop.
- R13: `tmr_hold_o` is 1 in every mode except the second alignment and run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_en_i | input | 1 | Power stage enable; low tristates the bridge |
| run_i | input | 1 | 1 = run, 0 = coast then brake |
| align_clk_i | input | 1 | Slow align reference clock, asynchronous |
| seq_inc_i | input | 1 | Manual step level; rising edge steps in run mode |
| zc_i | input | 1 | Back-EMF zero crossing seen, one-cycle flag |
| drv_en_o | output | 1 | Bridge driven per sequencer state |
| brake_o | output | 1 | All low-side switches on, high side off |
| seq_home_o | output | 1 | Hold sequencer at state 1 |
| inc_o | output | 1 | Single-step pulse to sequencer |
| inc2_o | output | 1 | Double-step pulse to sequencer |
| tmr_hold_o | output | 1 | Period, delay and mask counters stopped |
| ld_min_o | output | 1 | Load minimum delay and mask into timers |
| ld_period_o | output | 1 | Load delay and mask from measured period |

## Verification
Two functions of this block can fall in the same clock edge: a run drop and an alignment time-out, or a zero crossing and a manual-step rising edge. The first case is provoked by sweeping the run-drop instant over every cycle of a complete start-up from brake. For each instant, the bench requires the bridge to be off one clock later, no single-step or double-step pulse after the drop, and brake exactly BRK_DLY+1 clocks after the drop. The second case is provoked by raising the manual step and the crossing flag in the same cycle. The bench then expects exactly one step and no period load.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_CHECK,
    M_ALIGN1,
    M_ALIGN2,
    M_RUN,
    M_COAST,
    M_BRAKE
  } spd_mode_e;
endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], async_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/spd_clk_wdog.sv
module spd_clk_wdog #(
  parameter int WD_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ok_o
);
  logic [WD_W-1:0] cnt_q;

  // starts saturated: reference counts as missing until its first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '1;
    else if (tick_i)  cnt_q <= '0;
    else if (~&cnt_q) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = ~&cnt_q;
endmodule

// File: rtl/spd_align_timer.sv
module spd_align_timer #(
  parameter int A1_TICKS = 64,
  parameter int A2_TICKS = 192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic sel_i,
  output logic done_o
);
  localparam int AMAX = (A1_TICKS > A2_TICKS) ? A1_TICKS : A2_TICKS;
  localparam int AW   = $clog2(AMAX + 1);

  logic [AW-1:0] cnt_q, tgt;

  assign tgt    = sel_i ? AW'(A2_TICKS - 1) : AW'(A1_TICKS - 1);
  assign done_o = tick_i && (cnt_q == tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || done_o)  cnt_q <= '0;
    else if (tick_i)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spd_startup_ctrl.sv
module spd_startup_ctrl
  import spd_pkg::*;
#(
  parameter int A1_TICKS = 64,
  parameter int A2_TICKS = 192,
  parameter int WD_W     = 16,
  parameter int CHK_CYC  = 4096,
  parameter int BRK_DLY  = 100000,
  parameter int SYNC_STG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_en_i,
  input  logic run_i,
  input  logic align_clk_i,
  input  logic seq_inc_i,
  input  logic zc_i,
  output logic drv_en_o,
  output logic brake_o,
  output logic seq_home_o,
  output logic inc_o,
  output logic inc2_o,
  output logic tmr_hold_o,
  output logic ld_min_o,
  output logic ld_period_o
);
  localparam int CMAX = (CHK_CYC > BRK_DLY) ? CHK_CYC : BRK_DLY;
  localparam int CW   = $clog2(CMAX + 1);

  spd_mode_e mode_q, mode_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic seq_q, seq_rise;
  logic a_tick, clk_ok, a_done, in_align;
  logic inc_n, inc2_n, ldm_n, ldp_n;
  logic inc_q, inc2_q, ldm_q, ldp_q;

  spd_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(align_clk_i), .rise_o(a_tick)
  );

  spd_clk_wdog #(.WD_W(WD_W)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(a_tick), .ok_o(clk_ok)
  );

  assign in_align = (mode_q == M_ALIGN1) || (mode_q == M_ALIGN2);

  spd_align_timer #(.A1_TICKS(A1_TICKS), .A2_TICKS(A2_TICKS)) u_atmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!in_align), .tick_i(a_tick),
    .sel_i(mode_q == M_ALIGN2), .done_o(a_done)
  );

  assign seq_rise = seq_inc_i & ~seq_q;

  always_comb begin
    mode_n = mode_q;
    cnt_n  = cnt_q;
    inc_n  = 1'b0;
    inc2_n = 1'b0;
    ldm_n  = 1'b0;
    ldp_n  = 1'b0;
    if (!run_i) begin
      // run low wins over every other event in the cycle
      if (mode_q == M_COAST) begin
        if (cnt_q == CW'(BRK_DLY - 1)) mode_n = M_BRAKE;
        else                           cnt_n  = cnt_q + 1'b1;
      end else if (mode_q != M_BRAKE) begin
        mode_n = M_COAST;
        cnt_n  = '0;
      end
    end else begin
      unique case (mode_q)
        M_COAST, M_BRAKE: mode_n = M_IDLE;
        M_IDLE: if (out_en_i && clk_ok) begin
          mode_n = M_CHECK;
          cnt_n  = '0;
        end
        M_CHECK: begin
          if (!out_en_i) mode_n = M_IDLE;
          else if (zc_i) begin
            mode_n = M_RUN;       // still spinning: re-lock
            ldm_n  = 1'b1;
          end else if (cnt_q == CW'(CHK_CYC - 1)) begin
            mode_n = clk_ok ? M_ALIGN1 : M_IDLE;
            inc_n  = clk_ok;
          end else cnt_n = cnt_q + 1'b1;
        end
        M_ALIGN1: begin
          if (!out_en_i || !clk_ok) mode_n = M_IDLE;
          else if (a_done) begin
            mode_n = M_ALIGN2;
            inc2_n = 1'b1;
            ldm_n  = 1'b1;
          end
        end
        M_ALIGN2: begin
          if (!out_en_i || !clk_ok) mode_n = M_IDLE;
          else if (a_done) begin
            mode_n = M_RUN;
            inc2_n = 1'b1;
          end
        end
        M_RUN: begin
          if (!out_en_i) mode_n = M_IDLE;
          else begin
            inc_n = seq_rise || (zc_i && !seq_inc_i);
            ldp_n = zc_i && !seq_inc_i;
          end
        end
        default: mode_n = M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      cnt_q  <= '0;
      seq_q  <= 1'b0;
      inc_q  <= 1'b0;
      inc2_q <= 1'b0;
      ldm_q  <= 1'b0;
      ldp_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      seq_q  <= seq_inc_i;
      inc_q  <= inc_n;
      inc2_q <= inc2_n;
      ldm_q  <= ldm_n;
      ldp_q  <= ldp_n;
    end
  end

  assign drv_en_o    = out_en_i && (in_align || (mode_q == M_RUN));
  assign brake_o     = out_en_i && (mode_q == M_BRAKE);
  assign seq_home_o  = (mode_q == M_COAST) || (mode_q == M_BRAKE);
  assign tmr_hold_o  = !((mode_q == M_ALIGN2) || (mode_q == M_RUN));
  assign inc_o       = inc_q;
  assign inc2_o      = inc2_q;
  assign ld_min_o    = ldm_q;
  assign ld_period_o = ldp_q;
endmodule

// File: rtl/spd_startup_chk.sv
module spd_startup_chk
  import spd_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      out_en_i,
  input logic      run_i,
  input logic      seq_inc_i,
  input logic      zc_i,
  input logic      drv_en_o,
  input logic      brake_o,
  input logic      tmr_hold_o,
  input logic      inc_o,
  input logic      inc2_o,
  input logic      clk_ok,
  input spd_mode_e mode_q
);
  AST_RUN_LOW_DRV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !drv_en_o); // R10

  AST_BRAKE_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_o |-> (!drv_en_o && tmr_hold_o)); // R10

  AST_BRAKE_AFTER_COAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_BRAKE && $past(mode_q) != M_BRAKE) |-> $past(mode_q) == M_COAST); // R10

  AST_STEP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && inc2_o)); // R3

  AST_ALIGN_NO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_ALIGN1 || mode_q == M_ALIGN2) |=> !inc_o); // R6

  AST_RUN_ZC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_RUN && run_i && out_en_i && zc_i && !seq_inc_i) |=> inc_o); // R5

  AST_NO_START_WO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_IDLE && !clk_ok) |=> mode_q != M_CHECK); // R9

  AST_OE_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_en_i && run_i && (mode_q == M_CHECK || mode_q == M_ALIGN1 ||
     mode_q == M_ALIGN2 || mode_q == M_RUN)) |=> mode_q == M_IDLE); // R11
endmodule

bind spd_startup_ctrl spd_startup_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .out_en_i(out_en_i), .run_i(run_i),
  .seq_inc_i(seq_inc_i), .zc_i(zc_i), .drv_en_o(drv_en_o), .brake_o(brake_o),
  .tmr_hold_o(tmr_hold_o), .inc_o(inc_o), .inc2_o(inc2_o), .clk_ok(clk_ok),
  .mode_q(mode_q)
);

// File: tb/tb_spd_startup_ctrl.sv
module tb_spd_startup_ctrl;
  localparam int T   = 10;
  localparam int A1  = 4;
  localparam int A2  = 12;
  localparam int WDW = 6;
  localparam int CHK = 8;
  localparam int BRK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic out_en = 1'b1, run = 1'b0, align_clk = 1'b0, seq_inc = 1'b0, zc = 1'b0;
  logic align_en = 1'b1;
  logic drv_en, brake, seq_home, inc, inc2, tmr_hold, ld_min, ld_period;

  int n_chk = 0, n_fail = 0;
  int ph = 1, n_inc = 0, n_inc2 = 0, n_ldp = 0, n_ldm = 0, edges = 0;

  spd_startup_ctrl #(
    .A1_TICKS(A1), .A2_TICKS(A2), .WD_W(WDW), .CHK_CYC(CHK), .BRK_DLY(BRK)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .out_en_i(out_en), .run_i(run),
    .align_clk_i(align_clk), .seq_inc_i(seq_inc), .zc_i(zc),
    .drv_en_o(drv_en), .brake_o(brake), .seq_home_o(seq_home), .inc_o(inc),
    .inc2_o(inc2), .tmr_hold_o(tmr_hold), .ld_min_o(ld_min), .ld_period_o(ld_period)
  );

  initial forever #(T/2) clk = ~clk;

  // align reference: 8 system clocks per period, toggles away from clock edges
  initial begin
    #2;
    forever begin
      #(4*T);
      if (align_en) begin
        align_clk = ~align_clk;
        if (align_clk) edges++;
      end
    end
  end

  function automatic int wrap6(input int s);
    return ((s - 1) % 6) + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // one clock; sample away from the edge and update the sequencer model
  task automatic tick();
    @(posedge clk);
    #(T/4);
    if (seq_home) ph = 1;
    else begin
      if (inc)  ph = wrap6(ph + 1);
      if (inc2) ph = wrap6(ph + 2);
    end
    n_inc  += int'(inc);
    n_inc2 += int'(inc2);
    n_ldp  += int'(ld_period);
    n_ldm  += int'(ld_min);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic to_brake();
    run = 1'b0;
    ticks(BRK + 2);
  endtask

  initial begin
    #(T * 200000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e0, k, b_inc, b_inc2, b_ldp, b_ldm;
    ticks(4);
    rst_n = 1'b1;
    // R1: reset state and first brake
    tick();
    chk("R1 drv_en", int'(drv_en), 0);
    chk("R1 brake", int'(brake), 0);
    chk("R1 seq_home", int'(seq_home), 1);
    chk("R1 pulses", int'(inc | inc2 | ld_min | ld_period), 0);
    ticks(BRK - 1);
    chk("R1 brake before delay", int'(brake), 0);
    tick();
    chk("R1 brake after delay", int'(brake), 1);

    // R2..R4, R6, R13: align-and-go from brake
    b_inc = n_inc; b_ldm = n_ldm;
    run = 1'b1;
    ticks(CHK + 1);
    chk("R2 drv_en during check", int'(drv_en), 0);
    tick();
    chk("R2 drv_en at align", int'(drv_en), 1);
    chk("R2 single step", int'(inc), 1);
    chk("R2 state", ph, 2);
    chk("R13 hold in align1", int'(tmr_hold), 1);
    e0 = edges; k = 0;
    while (!inc2 && k < 400) begin
      seq_inc = (k == 1 || k == 3 || k == 4);
      tick();
      k++;
    end
    seq_inc = 1'b0;
    chk_rng("R3 align1 edges", edges - e0, A1 - 1, A1 + 1);
    chk("R3 state", ph, 4);
    chk("R4 ld_min at align2", n_ldm - b_ldm, 1);
    chk("R13 hold released", int'(tmr_hold), 0);
    e0 = edges; k = 0;
    tick();
    while (!inc2 && k < 400) begin tick(); k++; end
    chk_rng("R4 align2 edges", edges - e0, A2 - 1, A2 + 1);
    chk("R4 state", ph, 6);
    chk("R6 no single steps in align", n_inc - b_inc, 1);

    // R5: crossings with varied spacing
    for (int j = 0; j < 6; j++) begin
      ticks(j);
      b_ldp = n_ldp;
      zc = 1'b1;
      tick();
      zc = 1'b0;
      chk("R5 step on zc", int'(inc), 1);
      chk("R5 period load", n_ldp - b_ldp, 1);
      chk("R5 state", ph, wrap6(6 + j + 1));
      tick();
      chk("R5 single pulse", int'(inc), 0);
    end

    // R7: manual step with coincident crossing
    b_inc = n_inc; b_ldp = n_ldp;
    seq_inc = 1'b1; zc = 1'b1;
    tick();
    zc = 1'b0;
    chk("R7 coincident step", n_inc - b_inc, 1);
    chk("R7 no period load", n_ldp - b_ldp, 0);
    tick();
    zc = 1'b1;
    tick();
    zc = 1'b0;
    tick();
    chk("R7 zc ignored while high", n_inc - b_inc, 1);
    seq_inc = 1'b0;
    ticks(2);
    chk("R7 falling edge no step", n_inc - b_inc, 1);
    seq_inc = 1'b1;
    tick();
    chk("R7 second rise step", int'(inc), 1);
    seq_inc = 1'b0;
    tick();

    // R11, R8: output enable low then resync
    b_inc = n_inc; b_ldm = n_ldm;
    out_en = 1'b0;
    #1;
    chk("R11 drv_en off same cycle", int'(drv_en), 0);
    ticks(3);
    chk("R11 stays off", int'(drv_en), 0);
    out_en = 1'b1;
    tick();
    chk("R11 check before drive", int'(drv_en), 0);
    zc = 1'b1;
    tick();
    zc = 1'b0;
    chk("R8 resync drives", int'(drv_en), 1);
    chk("R8 ld_min", n_ldm - b_ldm, 1);
    chk("R8 no step", n_inc - b_inc, 0);

    // R10: coast then brake from run
    run = 1'b0;
    tick();
    chk("R10 drv off", int'(drv_en), 0);
    chk("R10 home", ph, 1);
    ticks(BRK - 1);
    chk("R10 no brake yet", int'(brake), 0);
    tick();
    chk("R10 brake", int'(brake), 1);
    out_en = 1'b0;
    #1;
    chk("R11 brake tristated", int'(brake), 0);
    out_en = 1'b1;
    #1;
    chk("R11 brake restored", int'(brake), 1);

    // R9: missing align clock
    align_en = 1'b0;
    ticks(80);
    run = 1'b1;
    ticks(CHK + 10);
    chk("R9 no start", int'(drv_en), 0);
    align_en = 1'b1;
    k = 0;
    while (!drv_en && k < 200) begin tick(); k++; end
    chk("R9 start after recovery", int'(drv_en), 1);
    b_inc2 = n_inc2;
    align_en = 1'b0;
    ticks(80);
    chk("R9 align abandoned", int'(drv_en), 0);
    chk("R9 no double step", n_inc2 - b_inc2, 0);
    to_brake();
    align_en = 1'b1;
    ticks(20);

    // R12: run drop at every offset of a start-up
    for (int d = 1; d < CHK + 2 + 8 * (A1 + A2) + 16; d++) begin
      run = 1'b1;
      ticks(d);
      b_inc = n_inc; b_inc2 = n_inc2;
      run = 1'b0;
      tick();
      chk("R10 drop drv off", int'(drv_en), 0);
      ticks(BRK);
      chk("R12 no step after drop", (n_inc - b_inc) + (n_inc2 - b_inc2), 0);
      chk("R10 brake after drop", int'(brake), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule